// File: doc/BRIEF.md
# Divergence Mask Stack for a Thread Group

This block tracks which lanes of a thread group are active while the group runs through a divergent region. The region is bracketed by two explicit operations. A split marks where the lanes separate, and a join marks where they meet again. Both act once for the whole group, whatever the current lane mask is.

On a split, the block records two stack entries. The lower entry keeps the full mask that was live before the split and is marked as a fall-through entry. The upper entry keeps the lanes whose predicate bit is set, together with the address that follows the split. The group then continues with the other lanes, those that were active and whose predicate bit is clear.

A join looks at the top entry and pops it. The first join after a split finds the upper entry, sends the fetch unit back to the stored address and hands over the predicated lanes. The second join finds the fall-through entry and only restores the full mask. Splits can nest up to the stack depth.

The stack level sits in a small state machine with three states:
- `ST_EMPTY`: no entries.
- `ST_PARTIAL`: there is room for at least one more split.
- `ST_FULL`: fewer than two slots are free.

The transitions are:
- **push-pair**: an accepted split; the level rises by two.
- **pop-one**: an accepted join; the level falls by one.
- **hold**: no accepted operation.

The next state is chosen from the new level. A split that arrives in `ST_FULL` raises the overflow flag. A join that arrives in `ST_EMPTY` raises the underflow flag. The block does not evaluate predicates and does not fetch instructions.

Top module: `warp_reconv_stack`

## Requirements
- R1: After reset the stack is empty. The first join raises `underflow`, and no operation is needed before it.
- R2: With neither strobe high, `next_mask` equals `cur_mask`, and `redirect_valid`, `overflow` and `underflow` are all 0.
- R3: An accepted split drives `next_mask = cur_mask & ~pred_bits` in the same cycle, with `redirect_valid` 0.
- R4: The first join after a split drives `redirect_valid` 1 and `redirect_pc = split PC + 1` (modulo 2^PC_W). It also drives `next_mask = split cur_mask & pred_bits`.
- R5: The second join after a split drives `next_mask` equal to the `cur_mask` seen at the split, with `redirect_valid` 0.
- R6: Nested splits unwind in last-in, first-out order.
- R7: A split with fewer than two free slots raises `overflow` and leaves `next_mask = cur_mask`. The stack is unchanged. With DEPTH = 8, the fifth nested split overflows.
- R8: A join on an empty stack raises `underflow`, leaves `next_mask = cur_mask`, and does not redirect.
- R9: When split and join are high in the same cycle, the split is dropped and only the join acts. `overflow` is never raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_req | input | 1 | Split operation strobe |
| join_req | input | 1 | Join operation strobe |
| pred_bits | input | LANES | Per-lane predicate selected by the split |
| cur_mask | input | LANES | Currently active lanes |
| cur_pc | input | PC_W | Address of the current instruction |
| next_mask | output | LANES | Mask the group should use next |
| redirect_valid | output | 1 | Fetch must continue from `redirect_pc` |
| redirect_pc | output | PC_W | Redirect target |
| overflow | output | 1 | Split refused for lack of room |
| underflow | output | 1 | Join on an empty stack |

## Verification
A wrong level or a wrong state shows at the very next join. Either the redirect flag appears on the wrong one of the paired joins, or `underflow` rises too early or too late. A wrong stored entry shows as a wrong mask or a wrong redirect target on the join that pops it, which may be several operations after the split that wrote it. For that reason the nested and overflow sequences are always unwound completely, down to an underflow.

// File: rtl/reconv_pkg.sv
package reconv_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } level_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SPLIT = 2'd1,
        OP_JOIN  = 2'd2
    } stack_op_e;

endpackage

// File: rtl/reconv_op_decode.sv
module reconv_op_decode
    import reconv_pkg::*;
(
    input  logic      split_req,
    input  logic      join_req,
    output stack_op_e op
);
    // Join wins: a split arriving together with a join is dropped.
    always_comb begin
        if (join_req)       op = OP_JOIN;
        else if (split_req) op = OP_SPLIT;
        else                op = OP_NONE;
    end
endmodule

// File: rtl/reconv_entry_store.sv
module reconv_entry_store #(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_pair,
    input  logic [PTR_W-1:0] level,
    input  logic [LANES-1:0] fall_mask,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  taken_pc,
    output logic             top_ft,
    output logic [LANES-1:0] top_mask,
    output logic [PC_W-1:0]  top_pc
);
    logic             ft_q   [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [PC_W-1:0]  pc_q   [DEPTH];

    logic [IDX_W-1:0] lo_idx, hi_idx, top_idx;

    assign lo_idx  = IDX_W'(level);
    assign hi_idx  = IDX_W'(level + PTR_W'(1));
    assign top_idx = (level == '0) ? '0 : IDX_W'(level - PTR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ft_q[i]   <= 1'b0;
                mask_q[i] <= '0;
                pc_q[i]   <= '0;
            end
        end else if (push_pair) begin
            ft_q[lo_idx]   <= 1'b1;
            mask_q[lo_idx] <= fall_mask;
            pc_q[lo_idx]   <= '0;
            ft_q[hi_idx]   <= 1'b0;
            mask_q[hi_idx] <= taken_mask;
            pc_q[hi_idx]   <= taken_pc;
        end
    end

    assign top_ft   = ft_q[top_idx];
    assign top_mask = mask_q[top_idx];
    assign top_pc   = pc_q[top_idx];
endmodule

// File: rtl/reconv_ctrl.sv
module reconv_ctrl
    import reconv_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_op_e        op,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] pred_bits,
    input  logic             top_ft,
    input  logic [LANES-1:0] top_mask,
    input  logic [PC_W-1:0]  top_pc,
    output logic             push_pair,
    output logic [PTR_W-1:0] level,
    output logic [LANES-1:0] next_mask,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             overflow,
    output logic             underflow
);
    localparam logic [PTR_W-1:0] ROOM_LIMIT = PTR_W'(DEPTH - 2);

    level_state_e     state_q, state_d;
    logic [PTR_W-1:0] level_q, level_d;

    function automatic level_state_e classify(input logic [PTR_W-1:0] lv);
        if (lv == '0)             return ST_EMPTY;
        else if (lv > ROOM_LIMIT) return ST_FULL;
        else                      return ST_PARTIAL;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // Transitions: push-pair, pop-one, hold
    always_comb begin
        level_d   = level_q;
        push_pair = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_SPLIT) begin
                    push_pair = 1'b1;
                    level_d   = level_q + PTR_W'(2);
                end
            end
            ST_PARTIAL: begin
                if (op == OP_SPLIT) begin
                    push_pair = 1'b1;
                    level_d   = level_q + PTR_W'(2);
                end else if (op == OP_JOIN) begin
                    level_d = level_q - PTR_W'(1);
                end
            end
            ST_FULL: begin
                if (op == OP_JOIN) level_d = level_q - PTR_W'(1);
            end
            default: level_d = '0;
        endcase
        state_d = classify(level_d);
    end

    // Outputs
    always_comb begin
        next_mask      = cur_mask;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        overflow       = 1'b0;
        underflow      = 1'b0;
        unique case (op)
            OP_SPLIT: begin
                if (state_q == ST_FULL) overflow = 1'b1;
                else                    next_mask = cur_mask & ~pred_bits;
            end
            OP_JOIN: begin
                if (state_q == ST_EMPTY) begin
                    underflow = 1'b1;
                end else begin
                    next_mask = top_mask;
                    if (!top_ft) begin
                        redirect_valid = 1'b1;
                        redirect_pc    = top_pc;
                    end
                end
            end
            default: ;
        endcase
    end

    assign level = level_q;
endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
    import reconv_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int PC_W    = 16,
    parameter int DEPTH   = 8,
    parameter int PC_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_req,
    input  logic             join_req,
    input  logic [LANES-1:0] pred_bits,
    input  logic [LANES-1:0] cur_mask,
    input  logic [PC_W-1:0]  cur_pc,
    output logic [LANES-1:0] next_mask,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             overflow,
    output logic             underflow
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    stack_op_e        op;
    logic             push_pair;
    logic [PTR_W-1:0] level;
    logic             top_ft;
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_pc;
    logic [LANES-1:0] taken_mask;
    logic [PC_W-1:0]  taken_pc;

    assign taken_mask = cur_mask & pred_bits;
    assign taken_pc   = cur_pc + PC_W'(PC_STEP);

    reconv_op_decode u_dec (
        .split_req (split_req),
        .join_req  (join_req),
        .op        (op)
    );

    reconv_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .op             (op),
        .cur_mask       (cur_mask),
        .pred_bits      (pred_bits),
        .top_ft         (top_ft),
        .top_mask       (top_mask),
        .top_pc         (top_pc),
        .push_pair      (push_pair),
        .level          (level),
        .next_mask      (next_mask),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .overflow       (overflow),
        .underflow      (underflow)
    );

    reconv_entry_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_pair  (push_pair),
        .level      (level),
        .fall_mask  (cur_mask),
        .taken_mask (taken_mask),
        .taken_pc   (taken_pc),
        .top_ft     (top_ft),
        .top_mask   (top_mask),
        .top_pc     (top_pc)
    );
endmodule

// File: rtl/reconv_checker.sv
module reconv_checker #(
    parameter int LANES = 8,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             split_req,
    input logic             join_req,
    input logic [LANES-1:0] cur_mask,
    input logic [PC_W-1:0]  cur_pc,
    input logic [LANES-1:0] next_mask,
    input logic             redirect_valid,
    input logic [PC_W-1:0]  redirect_pc,
    input logic             overflow,
    input logic             underflow,
    input logic [PTR_W-1:0] level
);
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_idle_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_req && !join_req) |-> (next_mask == cur_mask && !redirect_valid && !overflow && !underflow));

    assert_join_after_split_redirects_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && join_req && $past(split_req && !join_req && !overflow))
        |-> (redirect_valid && redirect_pc == PC_W'($past(cur_pc) + 1)));

    assert_second_join_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && join_req && $past(redirect_valid)) |-> !redirect_valid);

    assert_overflow_keeps_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (level == $past(level)));

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PTR_W'(DEPTH));

    assert_underflow_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (next_mask == cur_mask && !redirect_valid));

    assert_no_overflow_with_join_R9: assert property (@(posedge clk) disable iff (!rst_n)
        join_req |-> !overflow);
endmodule

bind warp_reconv_stack reconv_checker #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .split_req      (split_req),
    .join_req       (join_req),
    .cur_mask       (cur_mask),
    .cur_pc         (cur_pc),
    .next_mask      (next_mask),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .overflow       (overflow),
    .underflow      (underflow),
    .level          (level)
);

// File: tb/warp_reconv_stack_test.sv
module warp_reconv_stack_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int PC_W  = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic split_req = 1'b0, join_req = 1'b0;
    logic [LANES-1:0] pred_bits = '0, cur_mask = '0;
    logic [PC_W-1:0]  cur_pc = '0;
    logic [LANES-1:0] next_mask;
    logic             redirect_valid, overflow, underflow;
    logic [PC_W-1:0]  redirect_pc;

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             rv;
        logic [PC_W-1:0]  rpc;
        logic             ov;
        logic             un;
    } exp_t;

    typedef struct packed {
        logic             ft;
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  pc;
    } ment_t;

    exp_t  exp_q[$];
    string tag_q[$];
    ment_t model[$];
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .split_req(split_req), .join_req(join_req),
        .pred_bits(pred_bits), .cur_mask(cur_mask), .cur_pc(cur_pc),
        .next_mask(next_mask), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .overflow(overflow), .underflow(underflow)
    );

    // Driver: applies one operation and queues the expected outputs
    task automatic drive(input bit s, input bit j, input logic [LANES-1:0] p,
                         input logic [LANES-1:0] m, input logic [PC_W-1:0] pc, input string tag);
        exp_t  e;
        ment_t t;
        @(negedge clk);
        split_req = s; join_req = j; pred_bits = p; cur_mask = m; cur_pc = pc;
        e = '{mask: m, rv: 1'b0, rpc: '0, ov: 1'b0, un: 1'b0};
        if (j) begin
            if (model.size() == 0) e.un = 1'b1;
            else begin
                t = model.pop_back();
                e.mask = t.mask;
                if (!t.ft) begin e.rv = 1'b1; e.rpc = t.pc; end
            end
        end else if (s) begin
            if (model.size() + 2 > DEPTH) e.ov = 1'b1;
            else begin
                model.push_back('{ft: 1'b1, mask: m, pc: '0});
                model.push_back('{ft: 1'b0, mask: m & p, pc: pc + 16'd1});
                e.mask = m & ~p;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares outputs against the scoreboard before the next edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                total++;
                if (next_mask !== e.mask || redirect_valid !== e.rv || overflow !== e.ov ||
                    underflow !== e.un || (e.rv && redirect_pc !== e.rpc)) begin
                    bad++;
                    $display("FAIL %s: mask=%h rv=%b pc=%h ov=%b un=%b expected mask=%h rv=%b pc=%h ov=%b un=%b",
                             tg, next_mask, redirect_valid, redirect_pc, overflow, underflow,
                             e.mask, e.rv, e.rpc, e.ov, e.un);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R2: reset state and idle passthrough
        drive(0, 0, 8'h00, 8'hA5, 16'h0000, "R2 idle");
        drive(0, 1, 8'h00, 8'h3C, 16'h0000, "R1 empty after reset");
        // R3, R4, R5: single split
        drive(1, 0, 8'h0F, 8'hFF, 16'h0100, "R3 split");
        drive(0, 0, 8'h00, 8'hF0, 16'h0105, "R2 idle mid region");
        drive(0, 1, 8'h00, 8'hF0, 16'h0108, "R4 first join");
        drive(0, 1, 8'h00, 8'h0F, 16'h0103, "R5 second join");
        drive(0, 1, 8'h00, 8'hFF, 16'h0109, "R8 underflow");
        // R6: nesting
        drive(1, 0, 8'hF0, 8'hFF, 16'h0010, "R6 outer split");
        drive(1, 0, 8'h03, 8'h0F, 16'h0020, "R6 inner split");
        drive(0, 1, 8'h00, 8'h0C, 16'h0025, "R6 inner first join");
        drive(0, 1, 8'h00, 8'h03, 16'h0023, "R6 inner second join");
        drive(0, 1, 8'h00, 8'h0F, 16'h0030, "R6 outer first join");
        drive(0, 1, 8'h00, 8'hF0, 16'h0013, "R6 outer second join");
        drive(0, 1, 8'h00, 8'hFF, 16'h0040, "R8 underflow after nest");
        // R7: overflow on the fifth nested split
        drive(1, 0, 8'h01, 8'hFF, 16'h0030, "R7 split 1");
        drive(1, 0, 8'h02, 8'hFE, 16'h0031, "R7 split 2");
        drive(1, 0, 8'h04, 8'hFC, 16'h0032, "R7 split 3");
        drive(1, 0, 8'h08, 8'hF8, 16'h0033, "R7 split 4");
        drive(1, 0, 8'h10, 8'hF0, 16'h0034, "R7 overflow");
        for (int k = 0; k < 8; k++) drive(0, 1, 8'h00, 8'h55, 16'h0040, "R7 unwind");
        drive(0, 1, 8'h00, 8'h77, 16'h0041, "R8 underflow after unwind");
        // R9: simultaneous split and join
        drive(1, 1, 8'hFF, 8'hC3, 16'h0050, "R9 both on empty");
        drive(0, 1, 8'h00, 8'hC3, 16'h0051, "R9 split was dropped");
        drive(1, 0, 8'hAA, 8'hFF, 16'h0060, "R3 split for R9");
        drive(1, 1, 8'h0F, 8'h55, 16'h0070, "R9 both on occupied");
        drive(0, 1, 8'h00, 8'hAA, 16'h0071, "R9 second join");
        drive(0, 1, 8'h00, 8'hFF, 16'h0072, "R9 stack empty again");
        // R4: PC wrap
        drive(1, 0, 8'h81, 8'hFF, 16'hFFFF, "R3 split at top address");
        drive(0, 1, 8'h00, 8'h7E, 16'h0000, "R4 wrapped redirect");
        drive(0, 1, 8'h00, 8'h81, 16'h0001, "R5 after wrap");
        drive(0, 0, 8'h00, 8'h00, 16'h0000, "R2 final idle");
        @(negedge clk);
        split_req = 1'b0; join_req = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule